// File: doc/BRIEF.md
# PLL Startup Clock-Gating Controller

This block sits on the control-port side of a chip whose core clock comes from an on-chip PLL. It holds the only two registers the host can always reach. One is a clock control register whose bit 0 enables the core clock. The other is a 48-bit PLL configuration register that carries the PLL enable bit and a read-only lock status bit. The gated core clock enable stays low until the PLL is enabled, a lock indication has been received and the host has set the core enable bit.

While that condition is false, any host access to an address outside the two registers is refused. The refused access returns zero on a read, drops its write data and raises an error pulse. Once the condition holds, such accesses pass through to the core register file.

The control port carries a 16-bit start address and byte-wide beats. The address increments on every beat and a burst ends when the select drops. A write to the PLL register is collected in a shadow copy. The live register takes the new value only after an unbroken burst of exactly six bytes that starts at the first PLL byte.

A host brings the PLL up in five steps:
1. Write the enable bit to 0.
2. Rewrite the configuration.
3. Set the enable bit.
4. Poll the lock bit.
5. Set the core enable bit.

Top module: `pll_clkgate_ctrl`

## Requirements
- R1: After reset, `core_clk_en`, `pll_en`, `pll_cfg`, `cp_rvalid` and `acc_err` are all 0, and the core enable bit reads 0.
- R2: `core_clk_en` is 1 exactly when the core enable bit, the PLL enable bit and the synchronised lock are all 1. `pll_lock_in` reaches the synchronised lock through two flip-flops, so a change shows in `core_clk_en` after the second rising clock edge.
- R3: Address 0x4000 is the clock control register. Its bit 0 is the core enable bit and its other bits read 0. It can be read and written at any time.
- R4: Addresses 0x4002 to 0x4007 hold the PLL register, and byte 0x4002+k holds bits [47-8k:40-8k]. Bit 0 is the PLL enable bit and drives `pll_en`. Bit 1 is read-only and reads as the current lock status. The register can be read at any time.
- R5: The live PLL register changes only on the first clock edge after a write burst ends that started at 0x4002 and carried exactly six beats. Shorter, longer or offset bursts leave it unchanged.
- R6: While `core_clk_en` is 0, an access to any other address is refused. It does not assert `core_req`. A read returns 0x00. `acc_err` is 1 in the cycle after the beat.
- R7: While `core_clk_en` is 1, an access to any other address drives `core_req` in the same cycle as the beat, together with its address, direction and write data. Read data appears on `cp_rdata` one cycle after the beat, with `cp_rvalid` set.
- R8: Within a burst, each beat after the first uses the previous beat's address plus one, and `cp_addr` is ignored on those beats.
- R9: Clearing the PLL enable bit or dropping `pll_lock_in` clears both the lock status bit and `core_clk_en`, whatever the core enable bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cp_sel | input | 1 | Burst select; a burst ends when this goes low |
| cp_beat | input | 1 | One data beat this cycle |
| cp_wr | input | 1 | Burst direction, sampled on the first beat (1 = write) |
| cp_addr | input | 16 | Start address, sampled on the first beat |
| cp_wdata | input | 8 | Write byte |
| cp_rdata | output | 8 | Read byte, one cycle after the beat |
| cp_rvalid | output | 1 | Read data valid |
| acc_err | output | 1 | Refused access, one cycle after the beat |
| core_req | output | 1 | Forwarded access to the core register file |
| core_wr | output | 1 | Direction of the forwarded access |
| core_addr | output | 16 | Address of the forwarded access |
| core_wdata | output | 8 | Write byte of the forwarded access |
| core_rdata | input | 8 | Combinational read byte from the core register file |
| pll_lock_in | input | 1 | Asynchronous lock indication from the PLL |
| pll_en | output | 1 | PLL enable (0 = powered down) |
| pll_cfg | output | 48 | Live PLL configuration word |
| core_clk_en | output | 1 | Enable for the gated core clock |

## Verification
The bench drives each beat just after a falling edge and samples at the next falling edge.
- Forwarded accesses (`core_req`, `core_addr`, `core_wdata`) are combinational and are read 1 ns after the beat is driven.
- `cp_rdata`, `cp_rvalid` and `acc_err` are registered once and are read one cycle after their beat.
- A PLL commit is read at the falling edge after the edge where the select was seen low.
- A change on the lock input is checked one cycle after it is driven, when `core_clk_en` must not have moved yet, and again two cycles after, when it must have moved.

The bench sweeps write-burst lengths 1 to 8, several start offsets and a set of outside addresses. It predicts the register contents from the bytes it sent.

// File: rtl/pll_cg_pkg.sv
// Package: shared types for the PLL startup clock-gating controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package pll_cg_pkg;

    // Which register region the current beat addresses.
    typedef enum logic [1:0] {
        RGN_CLKCTL = 2'd0,
        RGN_PLL    = 2'd1,
        RGN_OTHER  = 2'd2
    } region_t;

    // Bit positions inside the last (least significant) PLL byte.
    localparam int unsigned PLL_EN_BIT   = 0;
    localparam int unsigned PLL_LOCK_BIT = 1;

endpackage

// File: rtl/cp_burst_track.sv
// Burst tracker: follows one control-port burst.
// Latches the start address and direction on the first beat, then
// produces the auto-incremented address of every later beat.
// Flags the cycle in which a burst has ended.
// Assumes cp_beat is only asserted while cp_sel is high.
module cp_burst_track #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_sel,
    input  logic              cp_beat,
    input  logic              cp_wr,
    input  logic [ADDR_W-1:0] cp_addr,
    output logic              beat_ok,
    output logic              first_beat,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_wr,
    output logic              burst_end
);

    logic              in_burst_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;

    // Decode the current beat from the latched burst state.
    always_comb begin
        beat_ok    = cp_beat & cp_sel;
        first_beat = beat_ok & ~in_burst_q;
        cur_addr   = first_beat ? cp_addr : addr_q;
        cur_wr     = first_beat ? cp_wr : wr_q;
        burst_end  = in_burst_q & ~cp_sel;
    end

    // Track burst membership and the next beat's address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_burst_q <= 1'b0;
            addr_q     <= '0;
            wr_q       <= 1'b0;
        end else if (!cp_sel) begin
            in_burst_q <= 1'b0;
        end else if (beat_ok) begin
            in_burst_q <= 1'b1;
            addr_q     <= cur_addr + ADDR_W'(1);
            wr_q       <= cur_wr;
        end
    end

    // R8: consecutive beats of one burst step the address by one.
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && !first_beat && $past(beat_ok))
            |-> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

endmodule

// File: rtl/pll_cfg_shadow.sv
// Configuration shadow: stages a byte-wise write of the wide PLL
// register. Copies the staged value to the live register only when
// a write burst that started at BASE carried exactly NBYTES beats
// and has ended. The read-only lock bit is stored as 0.
// Assumes first_beat and burst_end are never true together.
module pll_cfg_shadow #(
    parameter int unsigned       ADDR_W = 16,
    parameter int unsigned       NBYTES = 6,
    parameter logic [ADDR_W-1:0] BASE   = 'h4002
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  beat_ok,
    input  logic                  first_beat,
    input  logic                  cur_wr,
    input  logic [ADDR_W-1:0]     cur_addr,
    input  logic [7:0]            wdata,
    input  logic                  burst_end,
    output logic [8*NBYTES-1:0]   live
);
    import pll_cg_pkg::*;

    localparam int unsigned CFG_W = 8 * NBYTES;
    localparam int unsigned CNT_W = $clog2(NBYTES + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NBYTES + 1);

    logic [CFG_W-1:0] shadow_q;
    logic [CFG_W-1:0] live_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_ok_q;
    logic             commit;

    // One staging byte per address in the window.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam logic [ADDR_W-1:0] K_ADDR = BASE + ADDR_W'(k);
        // Capture a written byte at its own address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[8*(NBYTES-1-k) +: 8] <= '0;
            else if (beat_ok && cur_wr && cur_addr == K_ADDR)
                shadow_q[8*(NBYTES-1-k) +: 8] <= wdata;
        end
    end

    // Decide whether the burst that just ended is a complete write.
    always_comb begin
        commit = burst_end & start_ok_q & (cnt_q == CNT_W'(NBYTES));
    end

    // Count write beats and remember whether the burst began at BASE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            start_ok_q <= 1'b0;
        end else if (first_beat) begin
            cnt_q      <= cur_wr ? CNT_W'(1) : '0;
            start_ok_q <= cur_wr && (cur_addr == BASE);
        end else if (burst_end) begin
            cnt_q      <= '0;
            start_ok_q <= 1'b0;
        end else if (beat_ok && cur_wr && cnt_q != CNT_MAX) begin
            cnt_q      <= cnt_q + CNT_W'(1);
        end
    end

    // Copy the shadow into the live register on a valid commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (commit) begin
            live_q               <= shadow_q;
            live_q[PLL_LOCK_BIT] <= 1'b0;
        end
    end

    assign live = live_q;

    // R5: the live register moves only on the edge that commits.
    p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_q) |-> $past(commit));

endmodule

// File: rtl/lock_gate.sv
// Lock synchronizer and gate: brings the asynchronous lock indication
// into the clock domain and forms the lock status and the core clock
// enable. The enable is low whenever the PLL is disabled, lock is
// missing or the core enable bit is clear.
// Assumes SYNC_STAGES >= 2.
module lock_gate #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    input  logic pll_en,
    input  logic coren,
    output logic lock_st,
    output logic gate_en
);

    logic [SYNC_STAGES-1:0] sync_q;

    // Shift the lock indication through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], lock_in};
    end

    // Combine synchronized lock with the enables.
    always_comb begin
        lock_st = sync_q[SYNC_STAGES-1] & pll_en;
        gate_en = lock_st & coren;
    end

endmodule

// File: rtl/pll_clkgate_ctrl.sv
// Top: PLL startup clock-gating controller.
// Decodes control-port beats into the clock control register, the
// wide PLL register and everything else. Refuses accesses to
// everything else until the core clock is enabled. Forwards them to
// the core register file afterwards.
// Assumes core_rdata is a combinational function of core_addr.
module pll_clkgate_ctrl #(
    parameter int unsigned       ADDR_W      = 16,
    parameter int unsigned       PLL_BYTES   = 6,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CLKCTL_ADDR = 'h4000,
    parameter logic [ADDR_W-1:0] PLL_BASE    = 'h4002
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cp_sel,
    input  logic                   cp_beat,
    input  logic                   cp_wr,
    input  logic [ADDR_W-1:0]      cp_addr,
    input  logic [7:0]             cp_wdata,
    output logic [7:0]             cp_rdata,
    output logic                   cp_rvalid,
    output logic                   acc_err,
    output logic                   core_req,
    output logic                   core_wr,
    output logic [ADDR_W-1:0]      core_addr,
    output logic [7:0]             core_wdata,
    input  logic [7:0]             core_rdata,
    input  logic                   pll_lock_in,
    output logic                   pll_en,
    output logic [8*PLL_BYTES-1:0] pll_cfg,
    output logic                   core_clk_en
);
    import pll_cg_pkg::*;

    localparam int unsigned       CFG_W    = 8 * PLL_BYTES;
    localparam int unsigned       IDX_W    = $clog2(PLL_BYTES);
    localparam logic [ADDR_W-1:0] PLL_LAST = PLL_BASE + ADDR_W'(PLL_BYTES - 1);

    logic              beat_ok, first_beat, cur_wr, burst_end;
    logic [ADDR_W-1:0] cur_addr;
    logic [CFG_W-1:0]  live;
    logic [CFG_W-1:0]  live_view;
    logic              lock_st, gate_en;
    logic              coren_q;
    region_t           rgn;
    logic [ADDR_W-1:0] pll_off;
    logic [IDX_W-1:0]  pll_idx;
    logic [7:0]        pll_byte;
    logic [7:0]        rd_next;
    logic [7:0]        rdata_q;
    logic              rvalid_q, err_q;

    cp_burst_track #(.ADDR_W(ADDR_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cp_sel     (cp_sel),
        .cp_beat    (cp_beat),
        .cp_wr      (cp_wr),
        .cp_addr    (cp_addr),
        .beat_ok    (beat_ok),
        .first_beat (first_beat),
        .cur_addr   (cur_addr),
        .cur_wr     (cur_wr),
        .burst_end  (burst_end)
    );

    pll_cfg_shadow #(.ADDR_W(ADDR_W), .NBYTES(PLL_BYTES), .BASE(PLL_BASE)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_ok    (beat_ok),
        .first_beat (first_beat),
        .cur_wr     (cur_wr),
        .cur_addr   (cur_addr),
        .wdata      (cp_wdata),
        .burst_end  (burst_end),
        .live       (live)
    );

    lock_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_in (pll_lock_in),
        .pll_en  (live[PLL_EN_BIT]),
        .coren   (coren_q),
        .lock_st (lock_st),
        .gate_en (gate_en)
    );

    // Classify the current beat's address into a region.
    always_comb begin
        if (cur_addr == CLKCTL_ADDR)
            rgn = RGN_CLKCTL;
        else if (cur_addr >= PLL_BASE && cur_addr <= PLL_LAST)
            rgn = RGN_PLL;
        else
            rgn = RGN_OTHER;
    end

    // Select the addressed PLL byte, with live lock status substituted.
    always_comb begin
        live_view               = live;
        live_view[PLL_LOCK_BIT] = lock_st;
        pll_off                 = cur_addr - PLL_BASE;
        pll_idx                 = pll_off[IDX_W-1:0];
        pll_byte                = '0;
        for (int k = 0; k < PLL_BYTES; k++) begin
            if (pll_idx == IDX_W'(k))
                pll_byte = live_view[8*(PLL_BYTES-1-k) +: 8];
        end
    end

    // Forward permitted accesses to the core register file.
    always_comb begin
        core_req   = beat_ok & (rgn == RGN_OTHER) & gate_en;
        core_wr    = cur_wr;
        core_addr  = cur_addr;
        core_wdata = cp_wdata;
    end

    // Choose the byte returned for a read beat.
    always_comb begin
        unique case (rgn)
            RGN_CLKCTL: rd_next = {7'd0, coren_q};
            RGN_PLL:    rd_next = pll_byte;
            default:    rd_next = gate_en ? core_rdata : 8'h00;
        endcase
    end

    // Hold the core clock enable bit of the clock control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            coren_q <= 1'b0;
        else if (beat_ok && cur_wr && rgn == RGN_CLKCTL)
            coren_q <= cp_wdata[0];
    end

    // Register read data, its valid flag and the refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            rvalid_q <= beat_ok & ~cur_wr;
            err_q    <= beat_ok & (rgn == RGN_OTHER) & ~gate_en;
            rdata_q  <= (beat_ok && !cur_wr) ? rd_next : 8'h00;
        end
    end

    assign cp_rdata    = rdata_q;
    assign cp_rvalid   = rvalid_q;
    assign acc_err     = err_q;
    assign pll_en      = live[PLL_EN_BIT];
    assign pll_cfg     = live;
    assign core_clk_en = gate_en;

    // R9: a disabled PLL never leaves the core clock running.
    p_en_gates_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> !core_clk_en);

    // R2: the core clock needs the core enable bit.
    p_coren_gates_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !coren_q |-> !core_clk_en);

    // R6: no forwarding while the core clock is off.
    p_no_fwd_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> core_clk_en);

    // R6: a refusal pulse always follows a beat.
    p_err_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(beat_ok));

    // R6: a refused read returns zero.
    p_err_rdata_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && cp_rvalid) |-> (cp_rdata == 8'h00));

endmodule

// File: tb/tb_pll_clkgate_ctrl.sv
// Bench for pll_clkgate_ctrl: sweeps burst lengths, offsets and
// outside addresses and predicts results from the bytes it sends.
module tb_pll_clkgate_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cp_sel, cp_beat, cp_wr;
    logic [15:0] cp_addr;
    logic [7:0]  cp_wdata;
    logic [7:0]  cp_rdata;
    logic        cp_rvalid, acc_err;
    logic        core_req, core_wr;
    logic [15:0] core_addr;
    logic [7:0]  core_wdata, core_rdata;
    logic        pll_lock_in, pll_en, core_clk_en;
    logic [47:0] pll_cfg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  wbuf  [0:15];
    logic [7:0]  rbuf  [0:15];
    logic        ebuf  [0:15];
    logic        vbuf  [0:15];
    logic        qbuf  [0:15];
    logic        qwbuf [0:15];
    logic [15:0] qabuf [0:15];
    logic [7:0]  qdbuf [0:15];
    logic [47:0] exp_cfg;

    always #10 clk = ~clk;

    assign core_rdata = core_addr[7:0] ^ 8'h5A;

    pll_clkgate_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cp_sel      (cp_sel),
        .cp_beat     (cp_beat),
        .cp_wr       (cp_wr),
        .cp_addr     (cp_addr),
        .cp_wdata    (cp_wdata),
        .cp_rdata    (cp_rdata),
        .cp_rvalid   (cp_rvalid),
        .acc_err     (acc_err),
        .core_req    (core_req),
        .core_wr     (core_wr),
        .core_addr   (core_addr),
        .core_wdata  (core_wdata),
        .core_rdata  (core_rdata),
        .pll_lock_in (pll_lock_in),
        .pll_en      (pll_en),
        .pll_cfg     (pll_cfg),
        .core_clk_en (core_clk_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One burst of n beats; results land in the capture arrays.
    task automatic burst(input logic wr, input logic [15:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                rbuf[i-1] = cp_rdata; ebuf[i-1] = acc_err; vbuf[i-1] = cp_rvalid;
            end
            cp_sel   = 1'b1;
            cp_beat  = 1'b1;
            cp_wr    = (i == 0) ? wr : ~wr;
            cp_addr  = (i == 0) ? a : 16'hBEEF;
            cp_wdata = wbuf[i];
            #1;
            qbuf[i] = core_req; qwbuf[i] = core_wr;
            qabuf[i] = core_addr; qdbuf[i] = core_wdata;
        end
        @(negedge clk);
        rbuf[n-1] = cp_rdata; ebuf[n-1] = acc_err; vbuf[n-1] = cp_rvalid;
        cp_beat = 1'b0;
        cp_sel  = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [47:0] pack6();
        logic [47:0] v;
        for (int k = 0; k < 6; k++) v[8*(5-k) +: 8] = wbuf[k];
        v[1] = 1'b0;
        return v;
    endfunction

    // Read all six PLL bytes and compare with the prediction.
    task automatic read_pll(input string req, input logic lockbit);
        logic [7:0] e;
        burst(1'b0, 16'h4002, 6);
        for (int k = 0; k < 6; k++) begin
            e = exp_cfg[8*(5-k) +: 8];
            if (k == 5) e[1] = lockbit;
            check(req, {56'd0, rbuf[k]}, {56'd0, e});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] outs [0:4];
        outs[0] = 16'h0000; outs[1] = 16'h4001; outs[2] = 16'h4008;
        outs[3] = 16'h1234; outs[4] = 16'hFFFF;
        rst_n = 1'b0; cp_sel = 0; cp_beat = 0; cp_wr = 0;
        cp_addr = '0; cp_wdata = '0; pll_lock_in = 1'b0;
        for (int i = 0; i < 16; i++) wbuf[i] = '0;
        exp_cfg = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 clk_en", {63'd0, core_clk_en}, 64'd0);
        check("R1 pll_en", {63'd0, pll_en}, 64'd0);
        check("R1 cfg", {16'd0, pll_cfg}, 64'd0);
        check("R1 rvalid", {63'd0, cp_rvalid}, 64'd0);
        check("R1 err", {63'd0, acc_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        burst(1'b0, 16'h4000, 1);
        check("R1 R3 coren read", {55'd0, vbuf[0], rbuf[0]}, {55'd0, 1'b1, 8'h00});

        // R6: outside addresses refused before lock
        for (int j = 0; j < 5; j++) begin
            burst(1'b0, outs[j], 1);
            check("R6 rd data", {56'd0, rbuf[0]}, 64'd0);
            check("R6 rd err", {63'd0, ebuf[0]}, 64'd1);
            check("R6 rd fwd", {63'd0, qbuf[0]}, 64'd0);
            wbuf[0] = 8'hAA;
            burst(1'b1, outs[j], 1);
            check("R6 wr err", {63'd0, ebuf[0]}, 64'd1);
            check("R6 wr fwd", {63'd0, qbuf[0]}, 64'd0);
        end

        // R3: set core enable; still gated without lock (R2)
        wbuf[0] = 8'hFF;
        burst(1'b1, 16'h4000, 1);
        burst(1'b0, 16'h4000, 1);
        check("R3 coren=1", {56'd0, rbuf[0]}, 64'h01);
        check("R2 no lock gated", {63'd0, core_clk_en}, 64'd0);
        burst(1'b0, 16'h1234, 1);
        check("R6 coren only", {63'd0, ebuf[0]}, 64'd1);

        // R5: burst length sweep, only length 6 commits
        for (int len = 1; len <= 8; len++) begin
            for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h10 * len + i);
            burst(1'b1, 16'h4002, len);
            if (len == 6) exp_cfg = pack6();
            check($sformatf("R5 len%0d", len), {16'd0, pll_cfg}, {16'd0, exp_cfg});
        end
        for (int i = 0; i < 6; i++) wbuf[i] = 8'hC0 + 8'(i);
        burst(1'b1, 16'h4003, 6);
        check("R5 offset start", {16'd0, pll_cfg}, {16'd0, exp_cfg});
        burst(1'b1, 16'h4002, 3);
        burst(1'b1, 16'h4005, 3);
        check("R5 split burst", {16'd0, pll_cfg}, {16'd0, exp_cfg});
        check("R4 pll_en", {63'd0, pll_en}, {63'd0, exp_cfg[0]});
        read_pll("R4 R8 readback", 1'b0);

        // R2: lock passes two flops
        pll_lock_in = 1'b1;
        @(negedge clk);
        check("R2 one edge", {63'd0, core_clk_en}, 64'd0);
        @(negedge clk);
        check("R2 two edges", {63'd0, core_clk_en}, 64'd1);
        read_pll("R4 lock bit", 1'b1);

        // R7 R8: forwarding with address increment
        burst(1'b0, 16'h1230, 4);
        for (int i = 0; i < 4; i++) begin
            check("R7 fwd req", {63'd0, qbuf[i]}, 64'd1);
            check("R8 fwd addr", {48'd0, qabuf[i]}, {48'd0, 16'h1230 + 16'(i)});
            check("R7 rd data", {55'd0, vbuf[i], rbuf[i]}, {55'd0, 1'b1, 8'(8'h30 + i) ^ 8'h5A});
            check("R7 no err", {63'd0, ebuf[i]}, 64'd0);
        end
        for (int i = 0; i < 3; i++) wbuf[i] = 8'h71 + 8'(i);
        burst(1'b1, 16'h00FE, 3);
        for (int i = 0; i < 3; i++) begin
            check("R8 wr addr", {48'd0, qabuf[i]}, {48'd0, 16'h00FE + 16'(i)});
            check("R7 wr data", {55'd0, qwbuf[i], qdbuf[i]}, {55'd0, 1'b1, wbuf[i]});
        end

        // R9: lock loss gates clock and blocks access
        pll_lock_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 lock loss", {63'd0, core_clk_en}, 64'd0);
        read_pll("R9 lock bit low", 1'b0);
        burst(1'b0, 16'h1230, 1);
        check("R6 after loss", {63'd0, ebuf[0]}, 64'd1);

        // R9: clearing PLL enable gates clock despite lock
        pll_lock_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 relock", {63'd0, core_clk_en}, 64'd1);
        for (int i = 0; i < 6; i++) wbuf[i] = 8'h00;
        burst(1'b1, 16'h4002, 6);
        exp_cfg = pack6();
        check("R9 pll off", {62'd0, pll_en, core_clk_en}, 64'd0);
        read_pll("R9 off lock bit", 1'b0);

        // R2 R3: re-enable PLL, then clear core enable
        wbuf[5] = 8'h01;
        burst(1'b1, 16'h4002, 6);
        exp_cfg = pack6();
        check("R2 restart", {63'd0, core_clk_en}, 64'd1);
        wbuf[0] = 8'h00;
        burst(1'b1, 16'h4000, 1);
        check("R3 coren clear", {63'd0, core_clk_en}, 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule